// File: doc/BRIEF.md
# Cascaded Line Buffer for a Sliding Pixel Window

This block turns a serial stream of search-area pixels, delivered row after row, into a column of vertically adjacent pixels that leaves the block one column per accepted pixel. A row of on-chip RAMs, each one image row long, is chained so that each RAM's read data is the next RAM's write data. One pass of the stream through the chain moves every stored row one RAM further down. The column it produces feeds a square window register array that sits outside this block.

All RAMs share one address counter. The counter steps on every accepted pixel and returns to zero at a row length chosen at run time, which may be shorter than the RAM depth. The address that was read in one cycle becomes the write address in the next cycle, and the incoming pixel is delayed by the same one cycle. A read therefore always collects the previous row's word just before that word is replaced. The defaults are 31 taps and RAMs 256 words deep. A valid flag marks the columns in which every tap holds real image data.

Top module: `rb_cascade`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `col_vld` is 0. After reset the stream begins at column 0 with no rows counted.
- R2: Pixel (r, c) is the c-th pixel accepted in row r, counting from zero after reset. When it is accepted with r ≥ 1, the tap 0 output (`col_out[7:0]`) shows pixel (r-1, c) from the next clock edge on.
- R3: When pixel (r, c) is accepted, tap k (`col_out[8k+7:8k]`) shows pixel (r-1-k, c) from the next edge, for every k with r-1-k ≥ 0.
- R4: `col_vld` is 1 in the cycle after an accepted pixel exactly when at least TAPS complete rows came before that pixel's row. Otherwise it is 0.
- R5: A cycle with `pix_en` low advances nothing. `col_vld` reads 0 in the following cycle, every tap holds its value, and the column mapping of later pixels is unchanged.
- R6: The column index returns to 0 after `row_len` accepted pixels, for any `row_len` from 2 to DEPTH set during reset.
- R7: A `row_len` equal to the full RAM depth wraps correctly.
- R8: A reset in the middle of a stream restarts the row count. `col_vld` stays 0 until TAPS new rows have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| row_len | input | $clog2(DEPTH)+1 | Pixels per row, 2..DEPTH; change only in reset |
| pix_en | input | 1 | Accepts `pix_in` in this cycle |
| pix_in | input | 8 | Incoming search-area pixel |
| col_out | output | TAPS*8 | Column of TAPS pixels, tap k in bits 8k+7..8k |
| col_vld | output | 1 | Column holds TAPS real rows |

## Verification
Three things are hard to reach from the ports. The first is a read and a write at neighbouring addresses on the cycle after a row wraps. The second is a pause in the stream while a write is still pending. The third is a reset that lands while the RAMs still hold stale rows. The stimulus uses a small configuration and streams whole numbered images under several row lengths, one of them the full RAM depth. A gapped pass inserts an idle cycle after every third pixel, so the held column and the delayed write overlap. A reset is issued after two rows, and the valid flag is then checked to stay low until a full set of new rows has passed.

// File: rtl/rb_pkg.sv
// Shared pixel type for the cascaded line buffer.
package rb_pkg;
    localparam int unsigned RB_PIX_W = 8;
    typedef logic [RB_PIX_W-1:0] pix_t;
endpackage

// File: rtl/rb_line_ram.sv
// One line store: simple dual-port RAM, one registered read port, one write port.
// Assumes the controller never reads and writes the same word in one cycle;
// the read still returns the old word if that happens (read-before-write).
module rb_line_ram
    import rb_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output pix_t          rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  pix_t          wr_data
);
    pix_t mem [DEPTH];

    // Registered read; it holds its value while rd_en is low.
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end

    // Write port.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end
endmodule

// File: rtl/rb_addr_ctrl.sv
// Shared address pointer, one-cycle-delayed write address, saturating row
// counter and column-valid flag. Assumes 2 <= row_len <= DEPTH and that
// row_len is stable outside reset.
module rb_addr_ctrl #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned TAPS  = 31,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned RW = $clog2(TAPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW:0]   row_len,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] wr_addr,
    output logic          wr_en,
    output logic          tap_vld
);
    logic [RW-1:0] rows_seen;
    logic          at_end;

    // Last column of the row.
    assign at_end = ({1'b0, rd_addr} == (AW+1)'(row_len - 1'b1));

    // Step the pointer, pass its old value on as the write address, count rows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr   <= '0;
            wr_addr   <= '0;
            wr_en     <= 1'b0;
            rows_seen <= '0;
            tap_vld   <= 1'b0;
        end else begin
            wr_en   <= en;
            tap_vld <= en && (rows_seen == RW'(TAPS));
            if (en) begin
                wr_addr <= rd_addr;
                rd_addr <= at_end ? '0 : rd_addr + 1'b1;
                if (at_end && rows_seen != RW'(TAPS)) rows_seen <= rows_seen + 1'b1;
            end
        end
    end

    // R6: the pointer stays inside the programmed row.
    a_r6_addr_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, rd_addr} < row_len);
    // R6: after the last column the pointer restarts at zero.
    a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(en) && ({1'b0, $past(rd_addr)} == (AW+1)'($past(row_len) - 1'b1))
        |-> rd_addr == '0);
    // R5: an idle cycle leaves the pointer where it was.
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(en) |-> $stable(rd_addr));
    // R4: the row count never goes past the tap count.
    a_r4_rows_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        rows_seen <= RW'(TAPS));
endmodule

// File: rtl/rb_cascade.sv
// Cascaded line buffer: TAPS line RAMs in series, each one sharing the address.
// Tap k shows the pixel k+1 rows above the pixel just accepted, same column.
// Assumes 2 <= row_len <= DEPTH, changed only while rst_n is low.
module rb_cascade
    import rb_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned TAPS  = 31,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned PW = RB_PIX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW:0]        row_len,
    input  logic               pix_en,
    input  logic [PW-1:0]      pix_in,
    output logic [TAPS*PW-1:0] col_out,
    output logic               col_vld
);
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] wr_addr;
    logic          wr_en;
    pix_t          pix_d;
    pix_t          tap [TAPS];

    rb_addr_ctrl #(.DEPTH(DEPTH), .TAPS(TAPS)) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (pix_en),
        .row_len (row_len),
        .rd_addr (rd_addr),
        .wr_addr (wr_addr),
        .wr_en   (wr_en),
        .tap_vld (col_vld)
    );

    // Align the incoming pixel with the delayed write address.
    always_ff @(posedge clk) begin
        if (!rst_n)      pix_d <= '0;
        else if (pix_en) pix_d <= pix_in;
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_stage
        pix_t wdata;
        if (k == 0) begin : g_head
            assign wdata = pix_d;
        end else begin : g_link
            assign wdata = tap[k-1];
        end
        rb_line_ram #(.DEPTH(DEPTH)) i_ram (
            .clk     (clk),
            .rd_en   (pix_en),
            .rd_addr (rd_addr),
            .rd_data (tap[k]),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wdata)
        );
        assign col_out[k*PW +: PW] = tap[k];
    end

    // R3: a pending write never lands on the word being read (read-before-write order).
    a_r3_no_rw_clash: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && pix_en |-> wr_addr != rd_addr);
    // R4: valid only follows an accepted pixel.
    a_r4_vld_after_en: assert property (@(posedge clk) disable iff (!rst_n)
        col_vld |-> $past(pix_en));
    // R5: taps hold across an idle cycle.
    a_r5_taps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(pix_en) |-> $stable(col_out));
endmodule

// File: tb/test_rb_cascade.sv
module test_rb_cascade;
    localparam int unsigned DEPTH = 16;
    localparam int unsigned TAPS  = 4;
    localparam int unsigned AW    = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW:0]       row_len = (AW+1)'(DEPTH);
    logic              pix_en = 1'b0;
    logic [7:0]        pix_in = '0;
    logic [TAPS*8-1:0] col_out;
    logic              col_vld;

    int n_chk = 0;
    int n_bad = 0;
    int exp_tap [TAPS];
    bit known [TAPS];

    always #5 clk = ~clk;

    rb_cascade #(.DEPTH(DEPTH), .TAPS(TAPS)) i_rb_cascade (
        .clk(clk), .rst_n(rst_n), .row_len(row_len),
        .pix_en(pix_en), .pix_in(pix_in), .col_out(col_out), .col_vld(col_vld)
    );

    function automatic int pix_of(int r, int c);
        return (r * 29 + c * 3 + 11) & 255;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(int len);
        @(negedge clk);
        rst_n = 1'b0; pix_en = 1'b0; row_len = (AW+1)'(len);
        repeat (2) @(negedge clk);
        chk("R1 vld in reset", int'(col_vld), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 vld after reset", int'(col_vld), 0);
        for (int k = 0; k < TAPS; k++) known[k] = 1'b0;
    endtask

    // Stream rows of length len; optional idle after every third pixel.
    task automatic stream(int rows, int len, bit gaps, string req);
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < len; c++) begin
                @(negedge clk);
                pix_en = 1'b1; pix_in = 8'(pix_of(r, c));
                @(posedge clk); #1;
                chk({req, " R4 vld"}, int'(col_vld), (r >= TAPS) ? 1 : 0);
                for (int k = 0; k < TAPS; k++) begin
                    if (r - 1 - k >= 0) begin
                        exp_tap[k] = pix_of(r - 1 - k, c);
                        known[k] = 1'b1;
                        chk(k == 0 ? {req, " R2 tap0"} : {req, " R3 tap"},
                            int'(col_out[k*8 +: 8]), exp_tap[k]);
                    end
                end
                if (gaps && (c % 3 == 2)) begin
                    @(negedge clk);
                    pix_en = 1'b0; pix_in = 8'hA5;
                    @(posedge clk); #1;
                    chk("R5 idle vld", int'(col_vld), 0);
                    for (int k = 0; k < TAPS; k++)
                        if (known[k]) chk("R5 idle hold", int'(col_out[k*8 +: 8]), exp_tap[k]);
                end
            end
        end
        @(negedge clk);
        pix_en = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset(DEPTH);
        stream(TAPS + 2, DEPTH, 1'b0, "R7 full depth");
        do_reset(7);
        stream(TAPS + 2, 7, 1'b0, "R6 len7");
        do_reset(5);
        stream(TAPS + 3, 5, 1'b1, "R5 gapped");
        do_reset(2);
        stream(TAPS + 2, 2, 1'b0, "R6 len2");
        do_reset(9);
        stream(2, 9, 1'b0, "R8 pre");
        do_reset(9);
        stream(TAPS + 1, 9, 1'b0, "R8 restart");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule